// File: doc/BRIEF.md
# ADC host command interface controller

This block is a memory-mapped slave that gives a processor access to a bank of 16-bit converter configuration and result registers. Software does not address the bank directly. It writes command words to a command port. Each accepted command is decoded at once and acts on the internal bank. Its 16-bit result is staged for one command. The result then moves into a 15-word readback FIFO, which software drains through a data port.

Seven 32-bit registers sit on a simple single-cycle bus with valid, write, address and data signals. The registers hold configuration, sticky interrupt status, interrupt mask, FIFO status, the command and data ports, and a control register. The control register keeps the command channel blocked until software releases it. A level interrupt is raised from the status bits that are not masked.

Top module: `adc_cmd_host`

## Requirements
- R1: After reset the registers read as follows: configuration 0x00001814, interrupt status 0x00000200, mask 0xFFFFFFFF, control 0x00000010 and FIFO status 0x00000500. The bank and the FIFO are empty or zero, and irq is low.
- R2: The registers are at byte offsets 0x00 configuration, 0x04 interrupt status, 0x08 mask, 0x0C FIFO status (read-only), 0x10 command port (write-only), 0x14 data port (read-only) and 0x18 control. Any other access reads as 0 and writes change nothing; this includes offsets with address bits 1:0 not zero, writes to read-only registers and reads of the command port. Read data appears on the cycle after the read strobe.
- R3: A command word carries the opcode in bits 29:26, the bank index in bits 25:16 and the data in bits 15:0. The opcodes are 0 no-op, 1 read and 2 write. Any other opcode is discarded and pushes nothing.
- R4: A read or write command whose index is 128 or more is discarded and touches neither the bank nor the FIFO. A no-op is accepted with any index.
- R5: Every accepted command pushes the value held in the one-deep pending stage into the FIFO, then loads its own result into that stage. A read yields the bank entry; a write or no-op yields 0. A write also stores bits 15:0 in the bank. The pending stage resets to 0.
- R6: The FIFO holds 15 words. A push into a full FIFO is lost, but the pending stage is still replaced.
- R7: A read of the data port pops and returns the oldest word. When the FIFO is empty the read returns 0 and the level stays 0.
- R8: The FIFO status register always has bit 10 set (command queue empty). It reports the level in bits 15:12, sets bit 8 when the level is 0 and sets bit 9 when the level is 15.
- R9: Interrupt status bit 9 is set again on every cycle. Bit 8 is set one cycle after the FIFO level becomes strictly greater than configuration bits 19:16. Both bits are sticky, and writing 1 to a bit clears it.
- R10: A write to the mask keeps only bits 9:0. irq is high while any status bit is set whose mask bit is 0.
- R11: While control bit 4 is set, command-port writes are discarded. A write to control stores the written value ANDed with 0x00FFFEFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |

## Verification
The block produces results with three different delays. Register and command writes take effect at the strobe edge, so an access on the following cycle already sees the new bank contents, FIFO level and pending value. Read data is registered and is sampled one cycle after its strobe. Status bit 8 and irq follow the level with one extra register stage, so the bench lets two idle cycles pass before it reads interrupt status or samples irq after a change in level. All sampling happens on the falling clock edge.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    SEL_CFG  = 3'd0,
    SEL_ISTS = 3'd1,
    SEL_IMSK = 3'd2,
    SEL_FSTS = 3'd3,
    SEL_CMD  = 3'd4,
    SEL_DATA = 3'd5,
    SEL_CTRL = 3'd6
  } reg_sel_e;

  typedef enum logic [3:0] {
    OPC_NOP = 4'd0,
    OPC_RD  = 4'd1,
    OPC_WR  = 4'd2
  } opcode_e;

  localparam logic [31:0] CFG_RST   = 32'h0000_1814;
  localparam logic [31:0] CTRL_RST  = 32'h0000_0010;
  localparam logic [31:0] CTRL_KEEP = 32'h00FF_FEFF;
  localparam logic [31:0] MASK_KEEP = 32'h0000_03FF;

  // accept rule for a decoded command word
  function automatic logic cmd_ok(input logic [3:0] op, input logic [9:0] idx,
                                  input logic [10:0] lim);
    logic in_bank;
    in_bank = ({1'b0, idx} < lim);
    return (op == OPC_NOP) || (((op == OPC_RD) || (op == OPC_WR)) && in_bank);
  endfunction

  // FIFO status word from the current level
  function automatic logic [31:0] fsts_word(input logic [3:0] lvl, input logic [3:0] full_lvl);
    logic [31:0] w;
    w        = 32'h0;
    w[10]    = 1'b1;
    w[15:12] = lvl;
    w[8]     = (lvl == 4'd0);
    w[9]     = (lvl == full_lvl);
    return w;
  endfunction

  function automatic logic over_thresh(input logic [3:0] lvl, input logic [3:0] thr);
    return lvl > thr;
  endfunction

endpackage

// File: rtl/adc_regbank.sv
module adc_regbank #(
  parameter int ENTRIES = 128,
  parameter int DW      = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/adc_rb_fifo.sv
module adc_rb_fifo #(
  parameter int DEPTH  = 15,
  parameter int DW     = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    head,
  output logic [LVL_W-1:0] level
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (level != FULL);
  assign do_pop  = pop && (level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= wdata;
        wr_ptr      <= step(wr_ptr);
      end
      if (do_pop) rd_ptr <= step(rd_ptr);
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  assign head = (level == '0) ? '0 : mem[rd_ptr];

endmodule

// File: rtl/adc_cmd_host.sv
module adc_cmd_host
  import adc_host_pkg::*;
#(
  parameter int FIFO_DEPTH   = 15,
  parameter int BANK_ENTRIES = 128,
  parameter int ADDR_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
  localparam int BIDX_W = $clog2(BANK_ENTRIES);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);
  localparam logic [10:0] BANK_LIM = 11'(BANK_ENTRIES);

  // address decode
  logic       hi_zero, mapped, wr, rd;
  logic [2:0] word;

  if (ADDR_W > 5) begin : g_hi
    assign hi_zero = ~|bus_addr[ADDR_W-1:5];
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end

  assign word   = bus_addr[4:2];
  assign mapped = hi_zero && (bus_addr[1:0] == 2'b00);
  assign wr     = bus_valid && bus_write && mapped;
  assign rd     = bus_valid && !bus_write && mapped;

  // named internal events
  logic             cmd_wr, cmd_accept, chan_hold, push_req, pop_req, bank_we;
  logic [3:0]       cmd_op;
  logic [9:0]       cmd_idx;
  logic [15:0]      cmd_dat, bank_rdata, fifo_head, pend_q, pend_d;
  logic [LVL_W-1:0] fifo_level;
  logic [3:0]       thresh;

  logic [31:0] cfg_q, mask_q, ctrl_q;
  logic        gth_q;
  logic [31:0] ists_word;

  assign cmd_op     = bus_wdata[29:26];
  assign cmd_idx    = bus_wdata[25:16];
  assign cmd_dat    = bus_wdata[15:0];
  assign chan_hold  = ctrl_q[4];
  assign cmd_wr     = wr && (word == SEL_CMD);
  assign cmd_accept = cmd_wr && !chan_hold && cmd_ok(cmd_op, cmd_idx, BANK_LIM);
  assign bank_we    = cmd_accept && (cmd_op == OPC_WR);
  assign push_req   = cmd_accept;
  assign pop_req    = rd && (word == SEL_DATA);
  assign pend_d     = (cmd_op == OPC_RD) ? bank_rdata : 16'h0;
  assign thresh     = cfg_q[19:16];

  adc_regbank #(.ENTRIES(BANK_ENTRIES), .DW(16)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bank_we),
    .widx  (cmd_idx[BIDX_W-1:0]),
    .wdata (cmd_dat),
    .ridx  (cmd_idx[BIDX_W-1:0]),
    .rdata (bank_rdata)
  );

  adc_rb_fifo #(.DEPTH(FIFO_DEPTH), .DW(16)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_req),
    .pop   (pop_req),
    .wdata (pend_q),
    .head  (fifo_head),
    .level (fifo_level)
  );

  // pending stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= '0;
    else if (cmd_accept) pend_q <= pend_d;
  end

  // control and status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      mask_q <= '1;
      ctrl_q <= CTRL_RST;
      gth_q  <= 1'b0;
    end else begin
      if (wr && word == SEL_CFG)  cfg_q  <= bus_wdata;
      if (wr && word == SEL_IMSK) mask_q <= bus_wdata & MASK_KEEP;
      if (wr && word == SEL_CTRL) ctrl_q <= bus_wdata & CTRL_KEEP;
      gth_q <= (gth_q && !(wr && word == SEL_ISTS && bus_wdata[8]))
               || over_thresh(4'(fifo_level), thresh);
    end
  end

  // bit 9 is forced back on after every update, so it reads as 1
  assign ists_word = {22'h0, 1'b1, gth_q, 8'h0};
  assign irq       = |(ists_word[9:0] & ~mask_q[9:0]);

  // registered read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (word)
        SEL_CFG:  bus_rdata <= cfg_q;
        SEL_ISTS: bus_rdata <= ists_word;
        SEL_IMSK: bus_rdata <= mask_q;
        SEL_FSTS: bus_rdata <= fsts_word(4'(fifo_level), 4'(FULL_LVL));
        SEL_DATA: bus_rdata <= {16'h0, fifo_head};
        SEL_CTRL: bus_rdata <= ctrl_q;
        default:  bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/adc_cmd_host_chk.sv
module adc_cmd_host_chk #(
  parameter int LVL_W = 4,
  parameter int DEPTH = 15,
  parameter int LIM   = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic             cmd_accept,
  input logic             chan_hold,
  input logic [3:0]       cmd_op,
  input logic [9:0]       cmd_idx,
  input logic             push_req,
  input logic             pop_req,
  input logic [LVL_W-1:0] fifo_level,
  input logic [3:0]       thresh,
  input logic             gth_q
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  localparam logic [10:0]      LIMV = 11'(LIM);

  p_level_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= FULL);

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_level == FULL) |=> fifo_level == FULL);

  p_push_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && fifo_level < FULL) |=> fifo_level == $past(fifo_level) + 1'b1);

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && fifo_level == '0) |=> fifo_level == '0);

  p_hold_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && chan_hold) |-> !cmd_accept);

  p_bad_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (cmd_op == 4'd1 || cmd_op == 4'd2) && {1'b0, cmd_idx} >= LIMV) |-> !cmd_accept);

  p_bad_opcode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_op > 4'd2) |-> !cmd_accept);

  p_gth_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (4'(fifo_level) > thresh) |=> gth_q);

endmodule

bind adc_cmd_host adc_cmd_host_chk #(
  .LVL_W (LVL_W),
  .DEPTH (FIFO_DEPTH),
  .LIM   (BANK_ENTRIES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_wr     (cmd_wr),
  .cmd_accept (cmd_accept),
  .chan_hold  (chan_hold),
  .cmd_op     (cmd_op),
  .cmd_idx    (cmd_idx),
  .push_req   (push_req),
  .pop_req    (pop_req),
  .fifo_level (fifo_level),
  .thresh     (thresh),
  .gth_q      (gth_q)
);

// File: tb/adc_cmd_host_bench.sv
module adc_cmd_host_bench;

  localparam logic [4:0] A_CFG = 5'h00, A_ISTS = 5'h04, A_IMSK = 5'h08, A_FSTS = 5'h0C,
                         A_CMD = 5'h10, A_DATA = 5'h14, A_CTRL = 5'h18, A_GAP = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  adc_cmd_host u_adc_cmd_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle2();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd(input logic [3:0] op, input logic [9:0] idx,
                                      input logic [15:0] d);
    return {2'b00, op, idx, d};
  endfunction

  function automatic logic [31:0] fsts(input int lvl);
    logic [31:0] w;
    w = 32'h400 | (32'(lvl) << 12);
    if (lvl == 0)  w = w | 32'h100;
    if (lvl == 15) w = w | 32'h200;
    return w;
  endfunction

  task automatic t_reset();
    brd(A_CFG, rv);  check("R1 cfg", rv, 32'h0000_1814);
    brd(A_ISTS, rv); check("R1 ists", rv, 32'h0000_0200);
    brd(A_IMSK, rv); check("R1 mask", rv, 32'hFFFF_FFFF);
    brd(A_CTRL, rv); check("R1 ctrl", rv, 32'h0000_0010);
    brd(A_FSTS, rv); check("R1/R8 fsts", rv, 32'h0000_0500);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_hold();
    bwr(A_CMD, cmd(4'd0, 10'd0, 16'h0));
    brd(A_FSTS, rv); check("R11 held cmd dropped", rv, fsts(0));
    bwr(A_CTRL, 32'hFFFF_FFFF);
    brd(A_CTRL, rv); check("R11 ctrl and-mask", rv, 32'h00FF_FEFF);
    bwr(A_CMD, cmd(4'd0, 10'd0, 16'h0));
    brd(A_FSTS, rv); check("R11 still held", rv, fsts(0));
    bwr(A_CTRL, 32'h0);
    brd(A_CTRL, rv); check("R11 ctrl cleared", rv, 32'h0);
  endtask

  task automatic t_basic();
    bwr(A_CMD, cmd(4'd2, 10'd5, 16'h1234));
    bwr(A_CMD, cmd(4'd1, 10'd5, 16'h0));
    bwr(A_CMD, cmd(4'd0, 10'h3FF, 16'hFFFF));
    brd(A_FSTS, rv); check("R8/R4 level 3 after nop any index", rv, fsts(3));
    brd(A_DATA, rv); check("R5 first push zero", rv, 32'h0);
    brd(A_DATA, rv); check("R5 write yields zero", rv, 32'h0);
    brd(A_DATA, rv); check("R5 delayed read data", rv, 32'h1234);
    brd(A_DATA, rv); check("R7 empty pop zero", rv, 32'h0);
    brd(A_FSTS, rv); check("R7 level stays 0", rv, fsts(0));
  endtask

  task automatic t_bad();
    bwr(A_CMD, cmd(4'd1, 10'd200, 16'h0));
    brd(A_FSTS, rv); check("R4 bad read index", rv, fsts(0));
    bwr(A_CMD, cmd(4'd2, 10'd128, 16'hBEEF));
    brd(A_FSTS, rv); check("R4 bad write index", rv, fsts(0));
    bwr(A_CMD, cmd(4'd3, 10'd5, 16'h0));
    bwr(A_CMD, cmd(4'd15, 10'd5, 16'h0));
    brd(A_FSTS, rv); check("R3 unknown opcodes", rv, fsts(0));
    bwr(A_CMD, cmd(4'd1, 10'd0, 16'h0));
    bwr(A_CMD, cmd(4'd0, 10'd0, 16'h0));
    brd(A_DATA, rv); check("R5 pending after nop", rv, 32'h0);
    brd(A_DATA, rv); check("R4 bank0 untouched", rv, 32'h0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 17; i++) bwr(A_CMD, cmd(4'd2, 10'(i), 16'(32'h100 + i)));
    brd(A_FSTS, rv); check("R6/R8 full status", rv, fsts(15));
    for (int i = 0; i < 15; i++) brd(A_DATA, rv);
    check("R7 last zero", rv, 32'h0);
    for (int i = 0; i < 17; i++) bwr(A_CMD, cmd(4'd1, 10'(i), 16'h0));
    brd(A_FSTS, rv); check("R6 capped at 15", rv, fsts(15));
    brd(A_DATA, rv); check("R6 oldest zero", rv, 32'h0);
    for (int k = 0; k < 14; k++) begin
      brd(A_DATA, rv); check("R6/R7 order", rv, 32'h100 + 32'(k));
    end
    bwr(A_CMD, cmd(4'd0, 10'd0, 16'h0));
    brd(A_DATA, rv); check("R6 pending replaced while full", rv, 32'h110);
  endtask

  task automatic t_irq();
    idle2();
    brd(A_ISTS, rv); check("R9 sticky gth", rv, 32'h300);
    check("R10 masked irq", {31'h0, irq}, 32'h0);
    bwr(A_IMSK, 32'h1FF);
    brd(A_IMSK, rv); check("R10 mask rd", rv, 32'h1FF);
    check("R10 irq unmasked", {31'h0, irq}, 32'h1);
    bwr(A_ISTS, 32'h300); idle2();
    brd(A_ISTS, rv); check("R9 w1c, bit9 forced", rv, 32'h200);
    check("R9 irq after clear", {31'h0, irq}, 32'h1);
    bwr(A_IMSK, 32'hFFFF_FFFF);
    brd(A_IMSK, rv); check("R10 mask keep 9:0", rv, 32'h3FF);
    check("R10 irq off", {31'h0, irq}, 32'h0);
    bwr(A_CFG, 32'h0002_1814);
    brd(A_CFG, rv); check("R2 cfg rw", rv, 32'h0002_1814);
    bwr(A_IMSK, 32'h2FF);
    bwr(A_CMD, cmd(4'd0, 10'd0, 16'h0));
    bwr(A_CMD, cmd(4'd0, 10'd0, 16'h0));
    idle2();
    brd(A_ISTS, rv); check("R9 level equal thresh", rv, 32'h200);
    check("R10 irq low at thresh", {31'h0, irq}, 32'h0);
    bwr(A_CMD, cmd(4'd0, 10'd0, 16'h0));
    idle2();
    brd(A_ISTS, rv); check("R9 level above thresh", rv, 32'h300);
    check("R10 irq high", {31'h0, irq}, 32'h1);
    for (int i = 0; i < 3; i++) brd(A_DATA, rv);
    idle2();
    brd(A_ISTS, rv); check("R9 sticky after drain", rv, 32'h300);
    bwr(A_ISTS, 32'h100); idle2();
    brd(A_ISTS, rv); check("R9 cleared", rv, 32'h200);
    check("R10 irq dropped", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_map();
    brd(A_CMD, rv); check("R2 cmd port reads 0", rv, 32'h0);
    brd(A_GAP, rv); check("R2 unmapped read", rv, 32'h0);
    brd(5'h01, rv); check("R2 misaligned read", rv, 32'h0);
    bwr(A_FSTS, 32'hFFFF_FFFF);
    bwr(A_DATA, 32'h0000_ABCD);
    bwr(A_GAP, 32'hFFFF_FFFF);
    bwr(5'h02, 32'hFFFF_FFFF);
    brd(A_FSTS, rv); check("R2 ro writes ignored", rv, fsts(0));
    brd(A_CFG, rv); check("R2 stray writes ignored", rv, 32'h0002_1814);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hold();
    t_basic();
    t_bad();
    t_fill();
    t_irq();
    t_map();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule